// File: doc/BRIEF.md
# Clause 45 MDIO Station-Management Master

This block drives Clause 45 management frames toward external PHY devices. A host presents an operation code, a 5-bit port address, a 5-bit device address, a 16-bit word and a half-period divisor, then pulses `start`. The master derives MDC from the system clock and serialises a 64-bit frame. The frame has four parts: a 32-bit all-ones preamble, a 14-bit command, a 2-bit turnaround and a 16-bit field. MDIO is presented as a value plus an output enable, so the pad can float. At the end of a frame the master raises `done` for one cycle. After a read, `rd_word` holds the 16 bits that were shifted in.

Clause 45 uses indirect access. An address frame (opcode 00) sets the register pointer. A write frame (01) or a read frame (11) then acts on that pointer. Opcode 10 is refused without touching the bus.

The sequencer walks these states:
- IDLE goes to PRE on an accepted start.
- PRE goes to CMD after preamble bit 31.
- CMD goes to TA after command bit 45.
- TA goes to DATA after bit 47.
- DATA goes to DONE after bit 63.
- DONE returns to IDLE after one cycle.

Every state transition happens on an MDC falling edge, except DONE to IDLE and the start-driven move out of IDLE.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc` is 0, `mdio_oe` is 0, and `busy` and `done` are 0.
- R2: A frame begins with 32 bit times in which MDIO is driven to 1.
- R3: Bits 32..45 are driven as follows: start code 00, then the two opcode bits, then `port_addr` bit 4 down to bit 0, then `dev_addr` bit 4 down to bit 0.
- R4: For address (00) and write (01) frames, turnaround bits 46 and 47 are driven as 1 then 0.
- R5: For read frames (11), `mdio_oe` is 0 for bits 46 through 63.
- R6: For address and write frames, bits 48..63 carry `word_in` bit 15 first.
- R7: For a read, the 16 values seen on `mdio_i` at the MDC rising edges of bits 48..63 appear in `rd_word`, first sample in bit 15, by the cycle `done` is high.
- R8: MDIO value and enable change only while MDC is low. They update together with the MDC falling edge and hold through the high phase.
- R9: Each MDC half period lasts `half_div` system clocks, with 0 treated as 1. The divisor is latched at start, so changes during a frame have no effect.
- R10: A start with opcode 10 launches no frame and produces a one-cycle `cmd_rej` pulse in the following cycle. MDC stays low and `busy` stays 0.
- R11: `busy` is high from the cycle after an accepted start through the `done` cycle. `done` lasts one cycle. A start while busy is ignored.
- R12: Every frame contains exactly 64 MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, honoured only when idle |
| op | input | 2 | Opcode: 00 address, 01 write, 11 read, 10 refused |
| port_addr | input | 5 | Port address field |
| dev_addr | input | 5 | Device address field |
| word_in | input | 16 | Register address or write data |
| half_div | input | DIV_W | System clocks per MDC half period (0 means 1) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| cmd_rej | output | 1 | One-cycle pulse for a refused opcode |
| rd_word | output | 16 | Data captured by the last read |

## Verification
The bench records MDIO at every MDC rising edge and compares the frame field by field against a model built from the command. A swapped field or a bit sent LSB first therefore shows up as a mismatch in the command or data slice. Read frames check two things: the enable mask is released for both turnaround bits, and a bench-modelled PHY word is captured in order. A design that kept driving during turnaround, or shifted the wrong way, fails there. The bench changes the divisor and pulses start with different fields in the middle of a frame. A design that re-read the divisor would show uneven MDC periods, and one that restarted would emit a second frame, which the scoreboard flags. Opcode 10 and a zero divisor are also exercised: a design that launched a frame on the refused code, or divided by zero, would be caught.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RINC  = 2'b10,
        OP_READ  = 2'b11
    } mdio_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_CMD,
        S_TA,
        S_DATA,
        S_DONE
    } mdio_state_e;

    localparam int PRE_BITS   = 32;
    localparam int CMD_BITS   = 14;
    localparam int TA_BITS    = 2;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = PRE_BITS + CMD_BITS + TA_BITS + DATA_BITS;
    localparam int SHIFT_BITS = CMD_BITS + TA_BITS + DATA_BITS;

    localparam logic [1:0] SOF_CODE = 2'b00;
    localparam logic [1:0] TA_OWN   = 2'b10;

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             term;

    assign limit = (half_len == '0) ? DIV_W'(1) : half_len;
    assign term  = (cnt == limit - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // tick marks the system edge at which mdc changes level
    assign rise_tick = run && term && !mdc;
    assign fall_tick = run && term &&  mdc;

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         msb
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_word;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign msb = sr[W-1];

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         bit_in,
    output logic [W-1:0] word
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (capture) begin
            word <= {word[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_c45_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic [4:0]           port_addr,
    input  logic [4:0]           dev_addr,
    input  logic [DATA_BITS-1:0] word_in,
    input  logic [DIV_W-1:0]     half_div,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 done,
    output logic                 cmd_rej,
    output logic [DATA_BITS-1:0] rd_word
);

    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_PRE  = BIT_W'(PRE_BITS - 1);
    localparam logic [BIT_W-1:0] LAST_CMD  = BIT_W'(PRE_BITS + CMD_BITS - 1);
    localparam logic [BIT_W-1:0] LAST_TA   = BIT_W'(PRE_BITS + CMD_BITS + TA_BITS - 1);
    localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(FRAME_BITS - 1);

    mdio_state_e      state, state_n;
    logic [BIT_W-1:0] bit_cnt;
    logic [DIV_W-1:0] div_q;
    logic             rd_q;
    logic             rej_q;

    logic             launch;
    logic             refuse;
    logic             run;
    logic             rise_tick;
    logic             fall_tick;
    logic             tx_msb;
    logic             tx_shift;
    logic             rx_cap;
    logic [SHIFT_BITS-1:0] frame_word;

    assign launch = (state == S_IDLE) && start && (op != OP_RINC);
    assign refuse = (state == S_IDLE) && start && (op == OP_RINC);
    assign run    = (state == S_PRE) || (state == S_CMD) ||
                    (state == S_TA)  || (state == S_DATA);

    assign frame_word = {SOF_CODE, op, port_addr, dev_addr, TA_OWN, word_in};
    assign tx_shift   = fall_tick && ((state == S_CMD) || (state == S_TA) ||
                                      (state == S_DATA));
    assign rx_cap     = rise_tick && (state == S_DATA) && rd_q;

    mdio_mdc_div #(.DIV_W(DIV_W)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .half_len  (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_tx_shift #(.W(SHIFT_BITS)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .load_word (frame_word),
        .shift     (tx_shift),
        .msb       (tx_msb)
    );

    mdio_rx_shift #(.W(DATA_BITS)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rx_cap),
        .bit_in  (mdio_i),
        .word    (rd_word)
    );

    // next-state decode: phase boundaries fall on MDC falling edges
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (launch)                            state_n = S_PRE;
            S_PRE:  if (fall_tick && bit_cnt == LAST_PRE)  state_n = S_CMD;
            S_CMD:  if (fall_tick && bit_cnt == LAST_CMD)  state_n = S_TA;
            S_TA:   if (fall_tick && bit_cnt == LAST_TA)   state_n = S_DATA;
            S_DATA: if (fall_tick && bit_cnt == LAST_DATA) state_n = S_DONE;
            S_DONE:                                        state_n = S_IDLE;
            default:                                       state_n = S_IDLE;
        endcase
    end

    // state register and per-frame context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
            div_q   <= DIV_W'(1);
            rd_q    <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            state <= state_n;
            rej_q <= refuse;
            if (launch) begin
                bit_cnt <= '0;
                div_q   <= half_div;
                rd_q    <= (op == OP_READ);
            end else if (fall_tick) begin
                bit_cnt <= bit_cnt + BIT_W'(1);
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            S_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            S_CMD: begin
                mdio_o  = tx_msb;
                mdio_oe = 1'b1;
            end
            S_TA, S_DATA: begin
                mdio_o  = tx_msb;
                mdio_oe = !rd_q;
            end
            S_IDLE, S_DONE: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign busy    = (state != S_IDLE);
    assign done    = (state == S_DONE);
    assign cmd_rej = rej_q;

endmodule

// File: rtl/mdio_c45_checker.sv
module mdio_c45_checker (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic busy,
    input logic done,
    input logic cmd_rej
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc)); // R1

    AST_PREAMBLE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o)); // R2

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8

    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rej |-> (!busy && !mdc)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !mdc)); // R11

    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R11

endmodule

bind mdio_c45_master mdio_c45_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .done    (done),
    .cmd_rej (cmd_rej)
);

// File: tb/mdio_c45_master_tb_top.sv
`timescale 1ns/1ps
module mdio_c45_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [4:0]  port_addr = '0;
    logic [4:0]  dev_addr = '0;
    logic [15:0] word_in = '0;
    logic [7:0]  half_div = 8'd2;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        busy, done, cmd_rej;
    logic [15:0] rd_word;

    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_c45_master #(.DIV_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .port_addr(port_addr), .dev_addr(dev_addr), .word_in(word_in),
        .half_div(half_div), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i), .busy(busy), .done(done), .cmd_rej(cmd_rej),
        .rd_word(rd_word)
    );

    typedef struct {
        logic [63:0] frame;
        logic [63:0] oe_mask;
        bit          rd;
        logic [15:0] rword;
        int          div;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          nb = 0;
    logic [63:0] got_v, got_oe;
    realtime     t_prev = -1.0;
    realtime     per_min = 1.0e9;
    realtime     per_max = 0.0;
    bit          cur_rd = 1'b0;
    logic [15:0] cur_word = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic summary_and_end();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // monitor side: record line at each MDC rising edge
    always @(posedge mdc) begin
        #1;
        if (nb < 64) begin
            got_v[63-nb]  = mdio_o;
            got_oe[63-nb] = mdio_oe;
        end
        if (t_prev >= 0.0) begin
            if ($realtime - t_prev < per_min) per_min = $realtime - t_prev;
            if ($realtime - t_prev > per_max) per_max = $realtime - t_prev;
        end
        t_prev = $realtime;
        nb++;
    end

    // PHY model: drives turnaround zero and read data after falling edges
    always @(negedge mdc) begin
        #1;
        if (cur_rd && nb >= 47 && nb < 64) begin
            phy_en  = 1'b1;
            phy_val = (nb == 47) ? 1'b0 : cur_word[15-(nb-48)];
        end else begin
            phy_en = 1'b0;
        end
    end

    // scoreboard compare at end of frame
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R11", "unexpected frame", 64'd1, 64'd0);
            end else begin
                exp_t e;
                realtime pe;
                e  = q.pop_front();
                pe = 10.0 * ((e.div == 0) ? 1 : e.div);
                chk(nb == 64, "R12", "rising edge count", 64'(nb), 64'd64);
                chk(got_v[63:32] == e.frame[63:32], "R2", "preamble",
                    {32'd0, got_v[63:32]}, {32'd0, e.frame[63:32]});
                chk(got_v[31:18] == e.frame[31:18], "R3", "command bits",
                    64'(got_v[31:18]), 64'(e.frame[31:18]));
                chk(got_oe == e.oe_mask, e.rd ? "R5" : "R4", "enable mask",
                    got_oe, e.oe_mask);
                if (!e.rd) begin
                    chk(got_v[17:16] == 2'b10, "R4", "turnaround",
                        64'(got_v[17:16]), 64'd2);
                    chk(got_v[15:0] == e.frame[15:0], "R6", "data field",
                        64'(got_v[15:0]), 64'(e.frame[15:0]));
                end else begin
                    chk(rd_word == e.rword, "R7", "read word",
                        64'(rd_word), 64'(e.rword));
                end
                chk((per_min > pe - 0.01) && (per_max < pe + 0.01), "R9",
                    "MDC period ps", 64'($rtoi(per_max * 1000.0)),
                    64'($rtoi(pe * 1000.0)));
            end
        end
    end

    task automatic send(input logic [1:0] o, input logic [4:0] p,
                        input logic [4:0] d, input logic [15:0] w,
                        input logic [7:0] dv, input logic [15:0] pw,
                        input bit poke);
        exp_t e;
        e.rd      = (o == 2'b11);
        e.frame   = {32'hFFFF_FFFF, 2'b00, o, p, d, 2'b10, w};
        e.oe_mask = e.rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
        e.rword   = pw;
        e.div     = int'(dv);
        q.push_back(e);
        cur_rd   = e.rd;
        cur_word = pw;
        nb       = 0;
        t_prev   = -1.0;
        per_min  = 1.0e9;
        per_max  = 0.0;
        @(negedge clk);
        start = 1'b1; op = o; port_addr = p; dev_addr = d; word_in = w;
        half_div = dv;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after start", 64'(busy), 64'd1);
        if (poke) begin
            repeat (100) @(negedge clk);
            start = 1'b1; op = 2'b01; port_addr = ~p; dev_addr = ~d;
            word_in = ~w; half_div = 8'd3;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R11", "busy after done", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mdc == 1'b0, "R11", "no second frame",
            64'({busy, mdc}), 64'd0);
    endtask

    initial begin
        #750000;
        chk(1'b0, "R11", "watchdog expired, busy", 64'(busy), 64'd0);
        summary_and_end();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mdc == 1'b0, "R1", "mdc at reset", 64'(mdc), 64'd0);
        chk(mdio_oe == 1'b0, "R1", "oe at reset", 64'(mdio_oe), 64'd0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done at reset",
            64'({busy, done}), 64'd0);

        // R10 refused opcode
        start = 1'b1; op = 2'b10; port_addr = 5'd3; dev_addr = 5'd1;
        @(negedge clk);
        start = 1'b0;
        chk(cmd_rej == 1'b1, "R10", "reject pulse", 64'(cmd_rej), 64'd1);
        chk(busy == 1'b0, "R10", "busy on reject", 64'(busy), 64'd0);
        @(negedge clk);
        chk(cmd_rej == 1'b0, "R10", "reject pulse width", 64'(cmd_rej), 64'd0);
        begin
            bit moved = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mdc || mdio_oe || busy) moved = 1'b1;
            end
            chk(!moved, "R10", "bus quiet after reject", 64'(moved), 64'd0);
        end

        // address, write, reads, zero divisor, divisor change plus start while busy
        send(2'b00, 5'b10110, 5'b00011, 16'hA5C3, 8'd2, 16'h0000, 1'b0); // R3 R6
        send(2'b01, 5'b00001, 5'b11110, 16'h1234, 8'd4, 16'h0000, 1'b0); // R4 R6
        send(2'b11, 5'b01010, 5'b10101, 16'h0000, 8'd2, 16'hBEEF, 1'b0); // R5 R7
        send(2'b11, 5'b11111, 5'b00000, 16'hFFFF, 8'd1, 16'h8001, 1'b0); // R7
        send(2'b01, 5'b00000, 5'b11111, 16'h0FF0, 8'd0, 16'h0000, 1'b0); // R9
        send(2'b00, 5'b10001, 5'b01110, 16'h7E81, 8'd7, 16'h0000, 1'b1); // R9 R11

        chk(q.size() == 0, "R12", "frames outstanding", 64'(q.size()), 64'd0);
        summary_and_end();
    end

endmodule